// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Edge Interrupt

This block is an eight-bit general-purpose I/O port behind a small register interface. Each pin can be set as an input or as an output. An output pin drives a stored level, and it can also be released to high impedance. An input pin is brought into the clock domain through a two-flop synchroniser. Its value can then be inverted per pin before software reads it and before any edge is detected.

The block latches a pending flag for a pin when that pin's processed input goes from 0 to 1. Only input pins with their interrupt enable set can latch a flag. All pending flags are ORed into one interrupt line. Setting a pin's inversion bit turns the detection into a falling-edge detector on the raw pin. Software clears every pending flag by reading the level register, so no separate acknowledge is needed. If an edge arrives in the same cycle as that read, the new edge is kept. The register-access port is a plain strobe interface: reads are combinational and writes take effect at the clock edge. The pin signals and the interrupt line are plain control signals with no handshake.

Top module: `pin_port_irq`

## Requirements
- R1: After reset, all five configuration registers read 0x00, every pin is an output driving 0 with its output enable high, and `irq` is low.
- R2: A write strobe stores `reg_wdata` into the register chosen by `reg_addr`: 0 is interrupt enable, 1 is level, 2 is high-impedance enable, 3 is inversion, and 4 is direction (bit 1 means input). `reg_rdata` is combinational from `reg_addr`. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: `pin_out[i]` equals bit i of the level register. `pin_oe[i]` is 1 exactly when direction bit i is 0 and high-impedance bit i is 0.
- R4: A read of address 1 returns, for each input pin, the synchronised pin value XOR its inversion bit. For each output pin it returns the stored level bit.
- R5: A change on `pin_in` appears in a level read after two rising clock edges, and not after one.
- R6: An enabled input pin whose processed level goes from 0 to 1 sets its pending flag at the next clock edge. `irq` is the OR of all pending flags, so it goes high three edges after the pin changes.
- R7: A pin whose direction bit is 0 never sets a pending flag, even if its enable bit is 1 and its level toggles.
- R8: A read of address 1 clears every pending flag at the next edge. A pin whose new edge is detected in that same cycle keeps its flag.
- R9: With a pin's inversion bit set, a falling edge on that pin raises the interrupt, and a rising edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_rd | input | 1 | Read strobe; a read of address 1 clears pending flags |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Raw pin input levels |
| pin_out | output | 8 | Levels driven on output pins |
| pin_oe | output | 8 | Per-pin drive enable, 1 = driven |
| irq | output | 1 | OR of all pending flags |

## Verification
Register writes show on `pin_out`, `pin_oe` and the read data one edge after the write strobe. A pin change shows in a level read two edges later, and it raises `irq` three edges later. A clearing read drops `irq` one edge after the read. The bench holds a reference model that advances on every rising edge from the same inputs. Inputs change shortly after the falling edge, and all outputs are compared at the falling edge, so each result is taken in the cycle in which it is due. Directed checks also sample one cycle early to show that no result arrives before its time.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int PIN_W  = 8;
  localparam int ADDR_W = 3;
  localparam int NREG   = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_IEN = 3'd0,
    A_LVL = 3'd1,
    A_HIZ = 3'd2,
    A_INV = 3'd3,
    A_DIR = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pin_port_regs.sv
module pin_port_regs #(
  parameter int W      = 8,
  parameter int ADDR_W = 3,
  parameter int NREG   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      bank [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (wr && addr == ADDR_W'(r))         q <= wdata;
    end
    assign bank[r] = q;
  end
endmodule

// File: rtl/pin_port_sync.sv
module pin_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
    end
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_port_edge.sv
module pin_port_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] enable,
  input  logic [W-1:0] is_input,
  input  logic         clear,
  output logic [W-1:0] set_now,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;

  assign set_now = lvl_in & ~prev_q & enable & is_input;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= lvl_in;
      pend   <= (clear ? '0 : pend) | set_now;
    end
  end
endmodule

// File: rtl/pin_port_irq.sv
module pin_port_irq
  import pin_port_pkg::*;
#(
  parameter int W = PIN_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic [W-1:0] bank [NREG];
  logic [W-1:0] ien_q, out_q, hiz_q, inv_q, dir_q;
  logic [W-1:0] sync_q, lvl_in, set_now, pend_q;
  logic         clr;

  pin_port_regs #(.W(W), .ADDR_W(AW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .bank(bank)
  );

  assign ien_q = bank[A_IEN];
  assign out_q = bank[A_LVL];
  assign hiz_q = bank[A_HIZ];
  assign inv_q = bank[A_INV];
  assign dir_q = bank[A_DIR];

  pin_port_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  assign lvl_in = sync_q ^ inv_q;
  assign clr    = reg_rd && (reg_addr == A_LVL);

  pin_port_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .enable(ien_q),
    .is_input(dir_q), .clear(clr), .set_now(set_now), .pend(pend_q)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q & ~hiz_q;
  assign irq     = |pend_q;

  always_comb begin
    case (reg_addr)
      A_IEN:   reg_rdata = ien_q;
      A_LVL:   reg_rdata = (dir_q & lvl_in) | (~dir_q & out_q);
      A_HIZ:   reg_rdata = hiz_q;
      A_INV:   reg_rdata = inv_q;
      A_DIR:   reg_rdata = dir_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  reg_rdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq,
  input logic [W-1:0]  ien_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  pend_q,
  input logic [W-1:0]  set_now
);
  p_unused_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > AW'(4)) |-> (reg_rdata == '0));

  p_level_write_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(1)) |=> (pin_out == $past(reg_wdata)));

  p_no_drive_on_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);

  p_irq_needs_enabled_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (($past(ien_q) & $past(dir_q)) != '0));

  p_output_never_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(dir_q)) == '0));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(1)) |=> ((pend_q & ~$past(set_now)) == '0));
endmodule

bind pin_port_irq pin_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .ien_q(ien_q),
  .dir_q(dir_q), .pend_q(pend_q), .set_now(set_now)
);

// File: tb/test_pin_port_irq.sv
`timescale 1ns/1ps
module test_pin_port_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, pin_in = '0;
  logic [7:0] reg_rdata, pin_out, pin_oe;
  logic       irq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit [7:0] m_ien, m_out, m_hiz, m_inv, m_dir, m_s1, m_s2, m_prev, m_pend;

  always #10 clk = ~clk;

  pin_port_irq i_pin_port_irq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic bit [7:0] m_read(input bit [2:0] a);
    bit [7:0] lv;
    lv = m_s2 ^ m_inv;
    case (a)
      3'd0: return m_ien;
      3'd1: return (m_dir & lv) | (~m_dir & m_out);
      3'd2: return m_hiz;
      3'd3: return m_inv;
      3'd4: return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %02h expected %02h", req, cyc, act, exp);
    end
  endtask

  // model advances on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ien = 0; m_out = 0; m_hiz = 0; m_inv = 0; m_dir = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
    end else begin
      bit [7:0] lv, rise;
      lv   = m_s2 ^ m_inv;
      rise = lv & ~m_prev;
      for (int i = 0; i < 8; i++) begin
        if (reg_rd && reg_addr == 3'd1) m_pend[i] = 1'b0;
        if (rise[i] && m_ien[i] && m_dir[i]) m_pend[i] = 1'b1;
      end
      m_prev = lv;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_ien = reg_wdata;
          3'd1: m_out = reg_wdata;
          3'd2: m_hiz = reg_wdata;
          3'd3: m_inv = reg_wdata;
          3'd4: m_dir = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 pin_out", pin_out, m_out);
      chk("R3 pin_oe", pin_oe, ~m_dir & ~m_hiz);
      chk("R6 irq", {7'd0, irq}, {7'd0, |m_pend});
      chk(reg_addr == 3'd1 ? "R4 level read" : "R2 read data", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic step(); @(negedge clk); #2; endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_level();
    reg_addr = 3'd1; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_addr = 3'(a); #1;
      chk("R1 reset register", reg_rdata, 8'h00);
    end
    chk("R1 reset oe", pin_oe, 8'hFF);
    chk("R1 reset out", pin_out, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // R2 register writes, unused addresses
    wr(3'd0, 8'h5A); wr(3'd2, 8'h33); wr(3'd3, 8'hC3); wr(3'd1, 8'hA5);
    wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    reg_addr = 3'd6; #1; chk("R2 unused read", reg_rdata, 8'h00);
    reg_addr = 3'd0; #1; chk("R2 ien kept", reg_rdata, 8'h5A);
    reg_addr = 3'd3; #1; chk("R2 inv kept", reg_rdata, 8'hC3);
    chk("R3 out level", pin_out, 8'hA5);
    wr(3'd4, 8'h0F);
    chk("R3 oe masks", pin_oe, 8'hF0 & ~8'h33);
    wr(3'd3, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'h00);
    repeat (4) step();

    // R5 two-edge latency, R4 level read
    reg_addr = 3'd1;
    pin_in = 8'h0F;
    step(); chk("R5 not after one edge", reg_rdata, 8'hA0);
    step(); chk("R5 after two edges / R4", reg_rdata, 8'hAF);
    wr(3'd3, 8'h03);
    reg_addr = 3'd1; #1; chk("R4 inverted read", reg_rdata, 8'hAC);
    wr(3'd3, 8'h00);
    pin_in = 8'h00;
    repeat (4) step();
    rd_level();
    step();

    // R6 rising edge raises irq after three edges
    wr(3'd0, 8'hFF);
    step();
    pin_in = 8'h01;
    step(); step(); chk("R6 irq not early", {7'd0, irq}, 8'h00);
    step(); chk("R6 irq raised", {7'd0, irq}, 8'h01);
    rd_level();
    chk("R8 clear read", {7'd0, irq}, 8'h00);

    // R7 output pins never pend
    wr(3'd4, 8'h00);
    for (int k = 0; k < 4; k++) begin
      pin_in = 8'hFF; repeat (3) step();
      pin_in = 8'h00; repeat (3) step();
      wr(3'd1, 8'(k * 37));
    end
    chk("R7 no irq from outputs", {7'd0, irq}, 8'h00);

    // R9 inversion selects falling edge
    wr(3'd4, 8'h0F); wr(3'd3, 8'h04);
    pin_in = 8'h04; repeat (4) step();
    rd_level(); step();
    pin_in = 8'h00;
    repeat (3) step();
    chk("R9 falling edge irq", {7'd0, irq}, 8'h01);
    rd_level(); step();
    pin_in = 8'h04; repeat (4) step();
    chk("R9 rising edge ignored", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h00);
    pin_in = 8'h00; repeat (4) step();
    rd_level(); step();

    // R8 edge in same cycle as clearing read keeps flag
    pin_in = 8'h02;
    step(); step();
    rd_level();
    chk("R8 same-cycle edge kept", {7'd0, irq}, 8'h01);
    rd_level();
    chk("R8 cleared after", {7'd0, irq}, 8'h00);

    // multi-pin pattern
    pin_in = 8'h0B; repeat (4) step();
    chk("R6 multi-pin irq", {7'd0, irq}, 8'h01);
    rd_level(); step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule